// File: doc/BRIEF.md
# Instruction Sequence Expander

The expander sits in the front end between fetch and decode. Each fetched instruction arrives with a match flag and a sequence number from an upstream pattern matcher. An instruction that does not match goes straight through to decode. An instruction that does match is replaced by a stored sequence of template instructions. The expander emits that sequence one instruction per accepted handshake. While it does so it fills in register and immediate fields taken from the triggering instruction.

Every instruction leaving the block carries a two-level program counter: the PC and a sequence offset. A passed-through instruction has offset 0. A replacement instruction carries the trigger's PC and its 1-based position in the sequence, so a fault inside an expansion can be reported precisely. A reserved codeword opcode asks for expansion by itself: its low immediate bits name the sequence, and its register fields feed the templates. One stored sequence therefore serves many register choices. Templates are loaded through a write port. If a requested sequence is not resident, the block signals a flush and stalls before it tries again.

Top module: `instr_expander`

## Requirements
- R1: An instruction that is neither matched nor a codeword is emitted unchanged with offset 0 and its own PC. In that case in_ready equals out_ready. After reset, with no input, out_valid and out_flush are 0 and in_ready is 1.
- R2: A resident trigger is accepted (in_ready high) in a cycle that has no output. From the next cycle the replacement instructions appear with offsets 1, 2, 3 and so on, one per handshake, all carrying the trigger's PC.
- R3: Each of the three register selectors in a template is 2 bits wide: 0 selects the template's literal, 1 the trigger's rs (bits 25:21), 2 its rt (bits 20:16), 3 its rd (bits 15:11). The rs and rt results go to bits 25:21 and 20:16 of the output; a non-zero rd selector overwrites output bits 15:11.
- R4: With the immediate selector at 1, the low 16 output bits come from the trigger's low 16 bits. With it at 0 they come from the template's 16-bit literal. The output opcode (bits 31:26) always comes from the template.
- R5: When a template's emit-trigger bit is set, the output word is the trigger instruction itself, unchanged, and out_ded is 000.
- R6: out_ded bits {2,1,0} flag the rs, rt and rd fields as dedicated registers (numbers 32 to 39). A bit is set only when the template's dedicated flag is set and that field's selector is 0 (literal).
- R7: After the entry whose last bit is set is consumed, the block returns to pass-through. A sequence with no last bit ends after offset 2^OFF_W (16 by default).
- R8: During an expansion in_ready stays 0. While out_ready is low, the output word, PC and offset are held.
- R9: A trigger whose sequence is not resident raises out_flush for one cycle with in_ready at 0. The block then stalls for STALL_CYC cycles (30) with out_valid and in_ready at 0, and then looks the trigger up again. in_ready can therefore first rise STALL_CYC+1 cycles after the flush cycle.
- R10: An instruction with opcode CW_OP (6'h3F) is a trigger whatever the match flag says. Its sequence number is its low SEQID_W bits.
- R11: A template write stores tpl_data at offset tpl_off of sequence tpl_seq_id and makes that sequence resident. tpl_data layout: [43] emit-trigger, [42] last, [41:36] opcode, [35:34] rs select, [33] rs dedicated, [32:28] rs literal, [27:26] rt select, [25] rt dedicated, [24:20] rt literal, [19:18] rd select, [17] rd dedicated, [16] immediate select, [15:0] literal low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetch presents an instruction |
| in_ready | output | 1 | Instruction accepted this cycle |
| in_insn | input | 32 | Fetched instruction |
| in_pc | input | 32 | PC of the fetched instruction |
| in_match | input | 1 | Pattern matcher flags a trigger |
| in_seq_id | input | SEQID_W | Sequence number from the matcher |
| out_valid | output | 1 | Instruction available to decode |
| out_ready | input | 1 | Decode takes the instruction |
| out_word | output | 32 | Emitted instruction |
| out_ded | output | 3 | Dedicated-register flags for rs, rt, rd |
| out_pc | output | 32 | PC tag |
| out_off | output | OFF_W+1 | Sequence offset tag, 0 for pass-through |
| out_flush | output | 1 | Front-end flush on a non-resident sequence |
| tpl_we | input | 1 | Template write enable |
| tpl_seq_id | input | SEQID_W | Sequence number of the written template |
| tpl_off | input | OFF_W | Offset of the written template |
| tpl_data | input | 44 | Template contents |

## Verification
The assertions assume that fetch holds its instruction steady while in_valid is high and in_ready is low. This matters most on a miss, where the same trigger must still be there when the lookup is retried. They also assume that no template is rewritten for a slot whose sequence is being expanded. The stimulus keeps to both rules. Every input changes only on an accepted handshake. Template writes go only to slots that are idle, and the one write made during a stall goes to the sequence that caused the stall.

// File: rtl/instr_expander.sv
`timescale 1ns/1ps
module instr_expander #(
  parameter int RT_ENTRIES = 512,
  parameter int OFF_W = 4,
  parameter int SEQID_W = 8,
  parameter int STALL_CYC = 30,
  parameter logic [5:0] CW_OP = 6'h3F,
  localparam int TPL_W = 44,
  localparam int IDX_W = $clog2(RT_ENTRIES),
  localparam int SLOT_W = IDX_W - OFF_W,
  localparam int TAG_W = SEQID_W - SLOT_W,
  localparam int CNT_W = $clog2(STALL_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_insn,
  input  logic [31:0]        in_pc,
  input  logic               in_match,
  input  logic [SEQID_W-1:0] in_seq_id,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [31:0]        out_word,
  output logic [2:0]         out_ded,
  output logic [31:0]        out_pc,
  output logic [OFF_W:0]     out_off,
  output logic               out_flush,
  input  logic               tpl_we,
  input  logic [SEQID_W-1:0] tpl_seq_id,
  input  logic [OFF_W-1:0]   tpl_off,
  input  logic [TPL_W-1:0]   tpl_data
);

  typedef enum logic [1:0] {S_PASS, S_EXP, S_STALL} st_t;

  logic [TPL_W-1:0] ram [RT_ENTRIES];
  logic [TAG_W-1:0] tags [2**SLOT_W];
  logic [2**SLOT_W-1:0] tag_v;

  st_t st;
  logic [OFF_W-1:0] cur;
  logic [31:0] t_insn, t_pc;
  logic [SLOT_W-1:0] t_slot;
  logic [CNT_W-1:0] cnt;

  function automatic logic [4:0] pick(input logic [1:0] s, input logic [4:0] lit,
                                      input logic [31:0] t);
    case (s)
      2'd0: pick = lit;
      2'd1: pick = t[25:21];
      2'd2: pick = t[20:16];
      default: pick = t[15:11];
    endcase
  endfunction

  wire is_cw = in_insn[31:26] == CW_OP;
  wire trig = in_valid && (in_match || is_cw);
  wire [SEQID_W-1:0] req_id = is_cw ? in_insn[SEQID_W-1:0] : in_seq_id;
  wire [SLOT_W-1:0] req_slot = req_id[SLOT_W-1:0];
  wire hit = tag_v[req_slot] && tags[req_slot] == req_id[SEQID_W-1:SLOT_W];

  wire [TPL_W-1:0] tpl = ram[{t_slot, cur}];
  wire emit_trig = tpl[43];
  wire last = tpl[42] || (&cur);
  wire [4:0] f_rs = pick(tpl[35:34], tpl[32:28], t_insn);
  wire [4:0] f_rt = pick(tpl[27:26], tpl[24:20], t_insn);
  wire [15:0] low_base = tpl[16] ? t_insn[15:0] : tpl[15:0];
  wire [15:0] low = (tpl[19:18] == 2'd0) ? low_base
                  : {pick(tpl[19:18], 5'd0, t_insn), low_base[10:0]};
  wire [31:0] inst_word = emit_trig ? t_insn : {tpl[41:36], f_rs, f_rt, low};
  wire [2:0] inst_ded = emit_trig ? 3'b000 :
    {tpl[33] && tpl[35:34] == 2'd0, tpl[25] && tpl[27:26] == 2'd0,
     tpl[17] && tpl[19:18] == 2'd0};

  wire expanding = st == S_EXP;
  assign in_ready  = (st == S_PASS) && (trig ? hit : out_ready);
  assign out_valid = expanding || (st == S_PASS && in_valid && !trig);
  assign out_word  = expanding ? inst_word : in_insn;
  assign out_ded   = expanding ? inst_ded : 3'b000;
  assign out_pc    = expanding ? t_pc : in_pc;
  assign out_off   = expanding ? {1'b0, cur} + 1'b1 : '0;
  assign out_flush = (st == S_PASS) && trig && !hit;

  always_ff @(posedge clk) begin
    if (tpl_we) begin
      ram[{tpl_seq_id[SLOT_W-1:0], tpl_off}] <= tpl_data;
      tags[tpl_seq_id[SLOT_W-1:0]] <= tpl_seq_id[SEQID_W-1:SLOT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_v <= '0;
    else if (tpl_we) tag_v[tpl_seq_id[SLOT_W-1:0]] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_PASS;
      cur <= '0;
      t_insn <= '0;
      t_pc <= '0;
      t_slot <= '0;
      cnt <= '0;
    end else begin
      case (st)
        S_PASS: if (trig) begin
          if (hit) begin
            st <= S_EXP;
            cur <= '0;
            t_insn <= in_insn;
            t_pc <= in_pc;
            t_slot <= req_slot;
          end else begin
            st <= S_STALL;
            cnt <= CNT_W'(STALL_CYC - 1);
          end
        end
        S_EXP: if (out_ready) begin
          if (last) st <= S_PASS;
          else cur <= cur + 1'b1;
        end
        default: begin
          if (cnt == '0) st <= S_PASS;
          else cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_off == '0 |-> out_word == in_insn && out_pc == in_pc && in_ready == out_ready);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_off != '0 |=>
      out_off == '0 || out_off == (OFF_W+1)'($past(out_off) + 1'b1));

  p_pc_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_off != '0 |=> out_off == '0 || $stable(out_pc));

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_off != '0 |-> !in_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && out_off != '0 |=>
      out_valid && $stable(out_word) && $stable(out_off) && $stable(out_pc));

  p_flush_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_flush |=> !out_flush && !in_ready && !out_valid);

endmodule

// File: tb/instr_expander_test.sv
`timescale 1ns/1ps
module instr_expander_test;
  localparam int OFF_W = 4;
  localparam int STALL = 30;

  typedef struct packed {
    logic [31:0] w;
    logic [2:0] d;
    logic [31:0] pc;
    logic [OFF_W:0] off;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_match = 0, out_ready = 1, tpl_we = 0;
  logic [31:0] in_insn = 0, in_pc = 0;
  logic [7:0] in_seq_id = 0, tpl_seq_id = 0;
  logic [OFF_W-1:0] tpl_off = 0;
  logic [43:0] tpl_data = 0;
  logic in_ready, out_valid, out_flush;
  logic [31:0] out_word, out_pc;
  logic [2:0] out_ded;
  logic [OFF_W:0] out_off;

  int checks = 0, failures = 0;
  bit done = 0;
  item_t exp_q[$];
  string req_q[$];

  instr_expander uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_pc(in_pc), .in_match(in_match), .in_seq_id(in_seq_id),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_ded(out_ded),
    .out_pc(out_pc), .out_off(out_off), .out_flush(out_flush), .tpl_we(tpl_we),
    .tpl_seq_id(tpl_seq_id), .tpl_off(tpl_off), .tpl_data(tpl_data));

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expect_item(input logic [31:0] w, input logic [2:0] d, input logic [31:0] pc,
                             input int off, input string req);
    exp_q.push_back('{w: w, d: d, pc: pc, off: (OFF_W+1)'(off)});
    req_q.push_back(req);
  endtask

  function automatic logic [43:0] mk(input bit emit, input bit last, input logic [5:0] op,
      input logic [1:0] rss, input bit rsd, input logic [4:0] rsl,
      input logic [1:0] rts, input bit rtd, input logic [4:0] rtl,
      input logic [1:0] rds, input bit rdd, input bit ims, input logic [15:0] low);
    mk = {emit, last, op, rss, rsd, rsl, rts, rtd, rtl, rds, rdd, ims, low};
  endfunction

  task automatic load(input logic [7:0] id, input int off, input logic [43:0] d);
    tpl_we = 1; tpl_seq_id = id; tpl_off = OFF_W'(off); tpl_data = d;
    @(posedge clk); #1;
    tpl_we = 0;
  endtask

  task automatic present(input logic [31:0] i, input logic [31:0] p, input bit m,
                         input logic [7:0] id);
    in_valid = 1; in_insn = i; in_pc = p; in_match = m; in_seq_id = id;
  endtask

  task automatic finish_accept();
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 0; in_match = 0;
  endtask

  task automatic send(input logic [31:0] i, input logic [31:0] p, input bit m,
                      input logic [7:0] id);
    present(i, p, m, id);
    finish_accept();
  endtask

  task automatic pass(input logic [31:0] i, input logic [31:0] p, input string req);
    expect_item(i, 3'b000, p, 0, req);
    send(i, p, 1'b0, 8'd0);
  endtask

  task automatic expect_store(input logic [31:0] st, input logic [31:0] pc);
    expect_item({6'h02, st[25:21], 5'd1, 16'd26}, 3'b010, pc, 1, "R3 R6 shift");
    expect_item({6'h03, 5'd1, 5'd2, 5'd1, 11'd0}, 3'b111, pc, 2, "R6 compare");
    expect_item({6'h05, 5'd1, 5'd0, 16'h0040}, 3'b100, pc, 3, "R4 branch");
    expect_item(st, 3'b000, pc, 4, "R5 R7 trigger copy");
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (out_off != 0) check(!in_ready, "R8", "in_ready during expansion", 32'(in_ready), 0);
      if (out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R1", "unexpected output", out_word, 0);
        end else begin
          item_t e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          checks++;
          if (out_word !== e.w || out_ded !== e.d || out_pc !== e.pc || out_off !== e.off) begin
            failures++;
            $display("FAIL %s: word=%h ded=%b pc=%h off=%0d expected word=%h ded=%b pc=%h off=%0d",
                     r, out_word, out_ded, out_pc, out_off, e.w, e.d, e.pc, e.off);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] st1, st2, cw, tr6, miss;
    int n;
    repeat (3) @(negedge clk);
    check(!out_valid && !out_flush, "R1", "reset outputs", {out_valid, out_flush}, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check(in_ready && !out_valid, "R1", "idle after reset", {in_ready, out_valid}, 2);
    @(posedge clk); #1;

    // R11: load store-check sequence 5, codeword sequence 9, long sequence 6
    load(8'd5, 0, mk(0,0,6'h02, 2'd1,0,5'd0, 2'd0,1,5'd1, 2'd0,0, 0,16'd26));
    load(8'd5, 1, mk(0,0,6'h03, 2'd0,1,5'd1, 2'd0,1,5'd2, 2'd0,1, 0,{5'd1,11'd0}));
    load(8'd5, 2, mk(0,0,6'h05, 2'd0,1,5'd1, 2'd0,0,5'd0, 2'd0,0, 0,16'h0040));
    load(8'd5, 3, mk(1,1,6'h00, 2'd0,0,5'd0, 2'd0,0,5'd0, 2'd0,0, 0,16'h0));
    load(8'd9, 0, mk(0,0,6'h20, 2'd1,0,5'd0, 2'd0,0,5'd3, 2'd1,0, 0,16'h0));
    load(8'd9, 1, mk(0,1,6'h23, 2'd1,0,5'd0, 2'd0,0,5'd4, 2'd0,0, 0,16'd8));
    for (int k = 0; k < 16; k++)
      load(8'd6, k, mk(0,0,6'(6'h10 + k), 2'd2,0,5'd0, 2'd3,0,5'd0, 2'd0,0, 1,16'h0));

    pass(32'h8C42_0010, 32'h0000_0F00, "R1 pass a");
    pass(32'h0062_2020, 32'h0000_0F04, "R1 pass b");
    pass(32'hFFFF_FFFF & 32'h2000_0005, 32'h0000_0F08, "R10 non-codeword unmatched");

    st1 = {6'h2B, 5'd9, 5'd4, 16'd8};
    expect_store(st1, 32'h0000_1000);
    send(st1, 32'h0000_1000, 1'b1, 8'd5);
    pass(32'h0123_4567, 32'h0000_1004, "R7 pass after end");

    // R8 back-pressure with a waiting instruction
    st2 = {6'h2B, 5'd12, 5'd6, 16'hFFF0};
    expect_store(st2, 32'h0000_1100);
    send(st2, 32'h0000_1100, 1'b1, 8'd5);
    out_ready = 0;
    present(32'h0AAA_0001, 32'h0000_1104, 1'b0, 8'd0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(out_valid && out_off == 1, "R8", "held offset", 32'(out_off), 1);
      check(out_word == {6'h02, 5'd12, 5'd1, 16'd26}, "R8", "held word", out_word,
            {6'h02, 5'd12, 5'd1, 16'd26});
      check(!in_ready, "R8", "in_ready while held", 32'(in_ready), 0);
    end
    @(posedge clk); #1 out_ready = 1;
    expect_item(32'h0AAA_0001, 3'b000, 32'h0000_1104, 0, "R8 waiting instruction");
    finish_accept();

    // R10 codeword with two register parameters
    cw = {6'h3F, 5'd2, 5'd0, 16'd9};
    expect_item({6'h20, 5'd2, 5'd3, 5'd2, 11'd0}, 3'b000, 32'h0000_2000, 1, "R10 R3 cw r2 add");
    expect_item({6'h23, 5'd2, 5'd4, 16'd8}, 3'b000, 32'h0000_2000, 2, "R10 cw r2 load");
    send(cw, 32'h0000_2000, 1'b0, 8'd77);
    cw = {6'h3F, 5'd1, 5'd0, 16'd9};
    expect_item({6'h20, 5'd1, 5'd3, 5'd1, 11'd0}, 3'b000, 32'h0000_2010, 1, "R10 R3 cw r1 add");
    expect_item({6'h23, 5'd1, 5'd4, 16'd8}, 3'b000, 32'h0000_2010, 2, "R10 cw r1 load");
    send(cw, 32'h0000_2010, 1'b0, 8'd0);

    // R7 forced end, R4 immediate from trigger
    tr6 = {6'h08, 5'd3, 5'd7, 16'hA5C3};
    for (int k = 0; k < 16; k++)
      expect_item({6'(6'h10 + k), 5'd7, 5'd20, 16'hA5C3}, 3'b000, 32'h0000_3000, k + 1,
                  "R7 R4 long sequence");
    send(tr6, 32'h0000_3000, 1'b1, 8'd6);
    pass(32'h0BBB_0002, 32'h0000_3004, "R7 pass after forced end");

    // R9 miss on sequence 40, loaded during the stall
    miss = {6'h2B, 5'd1, 5'd2, 16'd4};
    expect_item(miss, 3'b000, 32'h0000_4000, 1, "R9 after stall");
    present(miss, 32'h0000_4000, 1'b1, 8'd40);
    @(negedge clk);
    check(out_flush && !in_ready && !out_valid, "R9", "flush cycle",
          {out_flush, in_ready, out_valid}, 3'b100);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 2) tpl_we = 1;
      tpl_seq_id = 8'd40; tpl_off = 0; tpl_data = mk(1,1,6'h0, 2'd0,0,5'd0, 2'd0,0,5'd0, 2'd0,0, 0,16'h0);
      if (n == 3) tpl_we = 0;
      if (!in_ready)
        check(!out_flush && !out_valid, "R9", "quiet stall", {out_flush, out_valid}, 0);
    end while (!in_ready && n < 100);
    check(n == STALL + 1, "R9", "cycles to retry", n, STALL + 1);
    @(posedge clk); #1 in_valid = 0; in_match = 0;
    pass(32'h0CCC_0003, 32'h0000_4004, "R1 pass after miss");

    n = 0;
    while (exp_q.size() != 0 && n < 200) begin @(negedge clk); n++; end
    check(exp_q.size() == 0, "R2", "drained", exp_q.size(), 0);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule